// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Data-Ready Flag

This block turns an asynchronous serial line into parallel characters. It runs on the system clock and advances on a one-cycle enable, `tick16`, that pulses sixteen times per bit period. When the line is idle and a low level is seen on a tick, the receiver treats it as a possible start bit. It checks that bit again half a bit later, then samples each data bit and the stop bit at the centre of its bit cell. The assembled character is right-aligned and copied into a receive buffer register. At the same moment the data-ready flag is raised, so the host knows a character is waiting.

The host sets the character length to 5, 6, 7 or 8 bits. A strobe tells the block that the buffer has been read. Two status flags come with every character: one marks a stop bit sampled low, and one marks a character that arrived before the previous one was read. A loop mode takes the receive line from the local transmitter's serial output instead of the external pin, for self-test. While reset is active, the receiver ignores the line, stays idle and clears its flags.

The controller is a four-state machine: `ST_IDLE`, `ST_START`, `ST_DATA` and `ST_STOP`. It has these transitions:
- IDLE to START on a tick with the line low (falling edge on an idle line).
- START to IDLE on the verification tick if the line is high again (false start).
- START to DATA on the verification tick if the line is still low.
- DATA to DATA on each data sample until the last bit.
- DATA to STOP on the sample of the last data bit.
- STOP to IDLE on the stop sample, which also loads the buffer.

Top module: `serial_rx_unit`

## Requirements
- R1: In idle, a low line on a tick starts a candidate start bit. The line is sampled again 8 ticks later. If it is high then, the candidate is dropped and no character is produced.
- R2: After a valid start, each data bit is sampled 16 ticks after the previous sample. The first data bit received becomes bit 0 of the character.
- R3: `len_sel` sets the character length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. For lengths under 8, the unused upper bits of `rx_data` read as zero.
- R4: The stop bit is sampled 16 ticks after the last data bit. `framing_err` is loaded with each character: 1 if the stop sample was low, 0 if it was high. It changes at no other time except reset.
- R5: `data_ready` rises in the cycle after a complete character is moved into the buffer. `rx_data` then holds that character.
- R6: `data_ready` is cleared only by a `rd_strobe` pulse or by reset. A character completing in the same cycle as a read keeps the flag set.
- R7: If a character completes while `data_ready` is still set and no read occurs in that cycle, `overrun_err` is set and the buffer is overwritten with the new character. A read or reset clears `overrun_err`.
- R8: While `loop_en` is 1, characters are taken from `loop_src` and `ser_in` has no effect.
- R9: While `rst` is 1, `ser_in` is ignored, the receiver returns to idle, and `data_ready`, `overrun_err` and `framing_err` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | Enable pulse, 16 per bit period |
| ser_in | input | 1 | External serial line, idle high |
| loop_en | input | 1 | 1 selects the loopback source |
| loop_src | input | 1 | Transmitter serial output used in loop mode |
| len_sel | input | 2 | Character length code (0 to 3 for 5 to 8 bits) |
| rd_strobe | input | 1 | One-cycle pulse: host read of the buffer |
| rx_data | output | 8 | Receive buffer register, right-aligned |
| data_ready | output | 1 | A character is waiting in the buffer |
| overrun_err | output | 1 | An unread character was overwritten |
| framing_err | output | 1 | The stop bit of the buffered character was low |

## Verification
The assertions check the flag rules on every cycle:
- `data_ready` rises only after a buffer load.
- `data_ready` clears on a read and holds otherwise.
- Overrun never appears without `data_ready`.
- The framing flag changes only on a load.
- Loads happen only on a tick.
- Reset clears the flags.
- Short characters are stored with zero upper bits.

Some behaviours can only be shown by the bench's scenarios: the bit ordering and centre sampling of real frames, the rejection of a short low glitch, the line selection in loop mode, and the ignoring of the line during reset. The bench covers these with random characters, lengths, stop levels and read patterns, checked against a reference model.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_t;

endpackage

// File: rtl/rx_line_sel.sv
module rx_line_sel #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ser_in,
    input  logic loop_en,
    input  logic loop_src,
    output logic line_s
);
    logic                   raw_line;
    logic [SYNC_STAGES-1:0] chain;

    // The external pin only reaches the chain when loop mode is off (R8)
    assign raw_line = loop_en ? loop_src : ser_in;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b1;
                else     chain[i] <= raw_line;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b1;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign line_s = chain[SYNC_STAGES-1];

endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
    import serial_rx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int OSR     = 16,
    parameter int MIN_LEN = 5,
    parameter int LEN_W   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              line,
    input  logic [LEN_W-1:0]  len_sel,
    output logic              char_done,
    output logic              stop_low,
    output logic [DATA_W-1:0] char_data
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);
    localparam int NB_W  = IDX_W + 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);

    rx_state_t         state, nxt;
    logic [CNT_W-1:0]  cnt;
    logic [IDX_W-1:0]  bit_idx;
    logic [IDX_W-1:0]  last_idx;
    logic [NB_W-1:0]   nbits;
    logic [NB_W-1:0]   drop;
    logic [DATA_W-1:0] shreg;
    logic              sample;

    assign nbits    = NB_W'(MIN_LEN) + NB_W'(len_sel);
    assign last_idx = IDX_W'(nbits - NB_W'(1));
    assign drop     = NB_W'(DATA_W) - nbits;

    // Sample point: centre of start bit, then one full bit apart
    always_comb begin
        sample = 1'b0;
        unique case (state)
            ST_IDLE:  sample = 1'b0;
            ST_START: sample = tick && (cnt == HALF_LAST);
            ST_DATA:  sample = tick && (cnt == FULL_LAST);
            ST_STOP:  sample = tick && (cnt == FULL_LAST);
        endcase
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (tick && !line) nxt = ST_START;
            ST_START: if (sample) nxt = line ? ST_IDLE : ST_DATA;
            ST_DATA:  if (sample && bit_idx == last_idx) nxt = ST_STOP;
            ST_STOP:  if (sample) nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // Tick counter, bit index and shift register
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            if (state == ST_IDLE || sample)
                cnt <= '0;
            else if (tick)
                cnt <= cnt + CNT_W'(1);

            if (state == ST_START)
                bit_idx <= '0;
            else if (state == ST_DATA && sample)
                bit_idx <= bit_idx + IDX_W'(1);

            // LSB first: new bits enter at the top and move down
            if (state == ST_DATA && sample)
                shreg <= {line, shreg[DATA_W-1:1]};
        end
    end

    // Outputs
    always_comb begin
        char_done = (state == ST_STOP) && sample;
        stop_low  = !line;
        char_data = shreg >> drop;
    end

endmodule

// File: rtl/rx_buffer.sv
module rx_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_fe,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              overrun_err,
    output logic              framing_err
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data     <= '0;
            data_ready  <= 1'b0;
            overrun_err <= 1'b0;
            framing_err <= 1'b0;
        end else if (load) begin
            rx_data     <= load_data;
            data_ready  <= 1'b1;
            overrun_err <= data_ready && !rd_strobe;
            framing_err <= load_fe;
        end else if (rd_strobe) begin
            data_ready  <= 1'b0;
            overrun_err <= 1'b0;
        end
    end

endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int MIN_LEN     = 5,
    parameter int LEN_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              ser_in,
    input  logic              loop_en,
    input  logic              loop_src,
    input  logic [LEN_W-1:0]  len_sel,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              data_ready,
    output logic              overrun_err,
    output logic              framing_err
);
    logic              line_s;
    logic              char_done;
    logic              stop_low;
    logic [DATA_W-1:0] char_data;

    rx_line_sel #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk      (clk),
        .rst      (rst),
        .ser_in   (ser_in),
        .loop_en  (loop_en),
        .loop_src (loop_src),
        .line_s   (line_s)
    );

    rx_ctrl #(
        .DATA_W  (DATA_W),
        .OSR     (OSR),
        .MIN_LEN (MIN_LEN),
        .LEN_W   (LEN_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick16),
        .line      (line_s),
        .len_sel   (len_sel),
        .char_done (char_done),
        .stop_low  (stop_low),
        .char_data (char_data)
    );

    rx_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk         (clk),
        .rst         (rst),
        .load        (char_done),
        .load_data   (char_data),
        .load_fe     (stop_low),
        .rd_strobe   (rd_strobe),
        .rx_data     (rx_data),
        .data_ready  (data_ready),
        .overrun_err (overrun_err),
        .framing_err (framing_err)
    );

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              tick16,
    input logic              rd_strobe,
    input logic              char_done,
    input logic [LEN_W-1:0]  len_sel,
    input logic [DATA_W-1:0] rx_data,
    input logic              data_ready,
    input logic              overrun_err,
    input logic              framing_err
);
    // R5
    dr_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(data_ready) |-> $past(char_done));

    // R6
    dr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (data_ready && rd_strobe && !char_done) |=> !data_ready);

    // R6
    dr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (data_ready && !rd_strobe) |=> data_ready);

    // R7
    ov_needs_dr_chk: assert property (@(posedge clk) disable iff (rst)
        overrun_err |-> data_ready);

    // R4
    fe_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !char_done |=> $stable(framing_err));

    // R2
    done_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        char_done |-> tick16);

    // R3
    short_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (char_done && len_sel == '0) |=> (rx_data[DATA_W-1 -: 3] == 3'b000));

    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (!data_ready && !overrun_err && !framing_err));

endmodule

bind serial_rx_unit serial_rx_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tick16      (tick16),
    .rd_strobe   (rd_strobe),
    .char_done   (char_done),
    .len_sel     (len_sel),
    .rx_data     (rx_data),
    .data_ready  (data_ready),
    .overrun_err (overrun_err),
    .framing_err (framing_err)
);

// File: tb/serial_rx_unit_test.sv
`timescale 1ns/1ps
module serial_rx_unit_test;

    localparam int BIT_CLKS = 64;   // 16 ticks, one tick every 4 clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16 = 1'b0;
    logic       ser_in = 1'b1;
    logic       loop_en = 1'b0;
    logic       loop_src = 1'b1;
    logic [1:0] len_sel = 2'd3;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready;
    logic       overrun_err;
    logic       framing_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [7:0] exp_buf = '0;
    logic       exp_dr = 1'b0;
    logic       exp_ov = 1'b0;
    logic       exp_fe = 1'b0;

    serial_rx_unit uut (
        .clk(clk), .rst(rst), .tick16(tick16), .ser_in(ser_in),
        .loop_en(loop_en), .loop_src(loop_src), .len_sel(len_sel),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .data_ready(data_ready),
        .overrun_err(overrun_err), .framing_err(framing_err)
    );

    always #4 clk = ~clk;

    initial begin
        int div = 0;
        forever begin
            @(negedge clk);
            tick16 = (div == 3);
            div = (div + 1) % 4;
        end
    end

    function automatic logic [7:0] trim(input logic [7:0] d, input int len);
        return d & ((8'h1 << len) - 8'h1);
    endfunction

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic chk_all(input string tag);
        chk({tag, " rx_data"}, rx_data, exp_buf);
        chk({tag, " data_ready"}, {7'd0, data_ready}, {7'd0, exp_dr});
        chk({tag, " overrun_err"}, {7'd0, overrun_err}, {7'd0, exp_ov});
        chk({tag, " framing_err"}, {7'd0, framing_err}, {7'd0, exp_fe});
    endtask

    task automatic drive(input logic v, input bit via_loop, input int clks);
        if (via_loop) loop_src = v; else ser_in = v;
        repeat (clks) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input int len, input bit stop_ok, input bit via_loop);
        len_sel = 2'(len - 5);
        drive(1'b0, via_loop, BIT_CLKS);
        for (int i = 0; i < len; i++) drive(d[i], via_loop, BIT_CLKS);
        if (stop_ok) drive(1'b1, via_loop, BIT_CLKS);
        else begin
            drive(1'b0, via_loop, 40);
            drive(1'b1, via_loop, 24);
        end
        drive(1'b1, via_loop, BIT_CLKS);
        exp_ov  = exp_dr;
        exp_dr  = 1'b1;
        exp_buf = trim(d, len);
        exp_fe  = !stop_ok;
    endtask

    task automatic host_read();
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        @(negedge clk);
        exp_dr = 1'b0;
        exp_ov = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R9 reset state
        chk_all("R9 reset");
        rst = 1'b0;
        repeat (10) @(negedge clk);

        // R2 R5 basic 8-bit character, LSB first
        send(8'hA5, 8, 1'b1, 1'b0);
        chk_all("R2 R5 8-bit A5");

        // R7 overrun: second char without read
        send(8'h3C, 8, 1'b1, 1'b0);
        chk_all("R7 overrun");

        // R6 read clears flags
        host_read();
        chk_all("R6 read");

        // R6 read while empty has no effect
        host_read();
        chk_all("R6 idle read");

        // R3 5-bit character with upper bits set in source
        send(8'hFF, 5, 1'b1, 1'b0);
        chk_all("R3 5-bit");
        host_read();

        // R4 framing error
        send(8'h5A, 7, 1'b0, 1'b0);
        chk_all("R4 framing");

        // R1 false start: glitch of 4 ticks, no new character
        host_read();
        drive(1'b0, 1'b0, 16);
        drive(1'b1, 1'b0, 3 * BIT_CLKS);
        chk_all("R1 false start");

        // R8 loop mode with external line held low
        loop_src = 1'b1;
        ser_in   = 1'b0;
        loop_en  = 1'b1;
        repeat (8) @(negedge clk);
        send(8'h96, 8, 1'b1, 1'b1);
        chk_all("R8 loop");
        ser_in  = 1'b1;
        repeat (4) @(negedge clk);
        loop_en = 1'b0;
        repeat (8) @(negedge clk);
        host_read();

        // R9 reset clears and ignores line
        send(8'h11, 6, 1'b1, 1'b0);
        rst = 1'b1;
        for (int k = 0; k < 6; k++) drive(k[0], 1'b0, 40);
        ser_in = 1'b1;
        repeat (8) @(negedge clk);
        rst = 1'b0;
        exp_dr = 0; exp_ov = 0; exp_fe = 0; exp_buf = 8'h00;
        repeat (12 * BIT_CLKS) @(negedge clk);
        chk_all("R9 reset ignore");

        // Random mix
        void'($urandom(32'h1F2E3D4C));
        for (int n = 0; n < 24; n++) begin
            logic [7:0] d = 8'($urandom);
            int len = 5 + int'($urandom % 4);
            bit ok = ($urandom % 5) != 0;
            bit lp = ($urandom % 3) == 0;
            if (($urandom % 2) == 0) host_read();
            if (lp) begin
                loop_src = 1'b1; ser_in = 1'b0; loop_en = 1'b1;
                repeat (8) @(negedge clk);
            end
            send(d, len, ok, lp);
            chk_all(lp ? "R8 random loop" : "R2 R3 R4 R7 random");
            if (lp) begin
                ser_in = 1'b1;
                repeat (4) @(negedge clk);
                loop_en = 1'b0;
                repeat (8) @(negedge clk);
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule